// File: doc/BRIEF.md
# NIC Interrupt Delay and Moderation Unit

This unit sits between a network controller's receive and transmit completion logic and the single interrupt line to the CPU. Each direction has two countdown timers. The packet-delay timer restarts on every completion. The absolute-delay timer starts on the first completion and is not pushed back by later ones. When either timer of a direction runs out, the unit asks the ring logic to write back completed descriptors for that direction and records a cause bit.

Cause bits collect in a pending register. They reach the line only through a mask and a throttle timer. The throttle timer enforces a minimum spacing between rising edges of the interrupt line. A cause that the throttle blocks is held and raised when the throttle interval ends. A post flagged as immediate skips the throttle. A read-and-clear of the pending register drops the line. A separate clear strobe also drops it.

All timer and throttle values count in ticks of 1024 ns. A prescaler derives the tick from the core clock, so `PRESCALE` must equal 1024 ns divided by the core clock period (256 at 250 MHz).

Top module: `nic_irq_moderator`

## Requirements
- R1: A tick occurs once every `PRESCALE` core cycles, counted from reset. A timer loaded with value N runs out on the Nth tick after it is loaded.
- R2: When a receive timer runs out, `rx_wb_req` pulses for one cycle in the following cycle. Cause bit 1 (receive timer) is set in that same cycle.
- R3: When a transmit timer runs out, `tx_wb_req` pulses for one cycle in the following cycle. Cause bit 0 (transmit descriptors written) is set in that same cycle.
- R4: Every completion reloads its direction's packet-delay timer, so the packet-delay timer runs out N ticks after the last completion.
- R5: The absolute-delay timer loads only on a completion that finds it idle. A writeback from either timer of that direction clears both timers.
- R6: A timer value of zero disables that timer. If the packet-delay value is zero, a completion requests writeback and sets the cause in the next cycle.
- R7: `irq` is high only while some pending cause is unmasked. Configuration writes use `cfg_sel` as follows: 0 = receive packet delay, 1 = receive absolute delay, 2 = transmit packet delay, 3 = transmit absolute delay, 4 = throttle interval. Other values are ignored.
- R8: Each rising edge of `irq` loads the throttle timer. A new rise waits until the throttle count reaches zero, and a held unmasked cause then raises `irq` without any further stimulus.
- R9: An external post with `post_now` set and an unmasked cause raises `irq` in the next cycle, even while the throttle runs.
- R10: A mask write takes effect in the next cycle. Masking every pending cause drops `irq`. Unmasking a pending cause raises `irq` if the throttle allows it.
- R11: `cause_rd` returns the pending bits on `cause_q`. It clears them, except bits set in the same cycle, and `irq` is low in the next cycle.
- R12: `irq_clr` drops `irq` in the next cycle. Causes that are still pending and unmasked raise the line again once the throttle allows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Receive packet completion strobe |
| tx_done | input | 1 | Transmit packet completion strobe |
| cfg_we | input | 1 | Timer configuration write enable |
| cfg_sel | input | 3 | Timer select (see R7) |
| cfg_wdata | input | TW | Timer value in ticks |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | NC | New mask (1 = cause enabled) |
| post_valid | input | 1 | External cause post |
| post_cause | input | NC | Cause bits to post |
| post_now | input | 1 | Post bypasses the throttle |
| cause_rd | input | 1 | Read-and-clear of the pending register |
| irq_clr | input | 1 | Drop the interrupt line |
| cause_q | output | NC | Pending cause bits |
| rx_wb_req | output | 1 | Receive descriptor writeback request pulse |
| tx_wb_req | output | 1 | Transmit descriptor writeback request pulse |
| irq | output | 1 | Interrupt line to the CPU |

## Verification
The bench builds the unit with `PRESCALE` = 4, `TW` = 8 and `NC` = 4. A tick then takes four cycles, so timer expiries, throttle hold-off and the tick phase at which a completion lands are all exercised within a few dozen cycles. Four cause bits leave two bits free for external posts beside the two timer causes. This lets immediate posts and mask re-evaluation be tested against causes that the timers did not raise.

// File: rtl/nic_irq_moderator.sv
module nic_irq_moderator #(
  parameter int PRESCALE = 256,
  parameter int TW       = 16,
  parameter int NC       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_done,
  input  logic          tx_done,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [TW-1:0] cfg_wdata,
  input  logic          mask_we,
  input  logic [NC-1:0] mask_wdata,
  input  logic          post_valid,
  input  logic [NC-1:0] post_cause,
  input  logic          post_now,
  input  logic          cause_rd,
  input  logic          irq_clr,
  output logic [NC-1:0] cause_q,
  output logic          rx_wb_req,
  output logic          tx_wb_req,
  output logic          irq
);
  localparam int PW        = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int CAUSE_TXD = 0;
  localparam int CAUSE_RXT = 1;
  localparam int NPATH     = 2;

  logic [PW-1:0] pre;
  logic          tick;
  assign tick = (pre == PW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)   pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + 1'b1;
  end

  logic [NPATH-1:0] done, fire, wb_q;
  assign done = {tx_done, rx_done};

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    logic [TW-1:0] pk_cfg, ab_cfg, pk_cnt, ab_cnt;

    assign fire[g] = (tick && pk_cnt == TW'(1)) || (tick && ab_cnt == TW'(1)) ||
                     (done[g] && pk_cfg == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pk_cfg <= '0;
        ab_cfg <= '0;
        pk_cnt <= '0;
        ab_cnt <= '0;
        wb_q[g] <= 1'b0;
      end else begin
        if (cfg_we && cfg_sel == 3'(2*g))     pk_cfg <= cfg_wdata;
        if (cfg_we && cfg_sel == 3'(2*g + 1)) ab_cfg <= cfg_wdata;
        if (fire[g]) begin
          pk_cnt <= '0;
          ab_cnt <= '0;
        end else begin
          if (done[g])                    pk_cnt <= pk_cfg;
          else if (tick && pk_cnt != '0)  pk_cnt <= pk_cnt - 1'b1;
          if (done[g] && ab_cnt == '0)    ab_cnt <= ab_cfg;
          else if (tick && ab_cnt != '0)  ab_cnt <= ab_cnt - 1'b1;
        end
        wb_q[g] <= fire[g];
      end
    end
  end

  assign rx_wb_req = wb_q[0];
  assign tx_wb_req = wb_q[1];

  logic [NC-1:0] pend, mask, hw_set, pend_n, mask_n;
  logic [TW-1:0] thr_cfg, thr_cnt;
  logic          live, imm, irq_n;

  always_comb begin
    hw_set            = '0;
    hw_set[CAUSE_RXT] = fire[0];
    hw_set[CAUSE_TXD] = fire[1];
  end

  assign pend_n = (cause_rd ? '0 : pend) | hw_set | (post_valid ? post_cause : '0);
  assign mask_n = mask_we ? mask_wdata : mask;
  assign live   = |(pend_n & mask_n);
  assign imm    = post_valid && post_now && |(post_cause & mask_n);
  assign irq_n  = !(cause_rd || irq_clr) && live && (irq || thr_cnt == '0 || imm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      mask    <= '0;
      thr_cfg <= '0;
      thr_cnt <= '0;
      irq     <= 1'b0;
    end else begin
      pend <= pend_n;
      mask <= mask_n;
      irq  <= irq_n;
      if (cfg_we && cfg_sel == 3'd4) thr_cfg <= cfg_wdata;
      if (irq_n && !irq)                thr_cnt <= thr_cfg;
      else if (tick && thr_cnt != '0)   thr_cnt <= thr_cnt - 1'b1;
    end
  end

  assign cause_q = pend;

  AST_RX_WB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wb_req |-> cause_q[CAUSE_RXT]);                                   // R2
  AST_TX_WB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wb_req |-> cause_q[CAUSE_TXD]);                                   // R3
  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(cause_q & mask));                                          // R7
  AST_RISE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(thr_cnt) == '0 || $past(post_valid && post_now))); // R8
  AST_RISE_LOADS_THR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> thr_cnt == $past(thr_cfg));                           // R8
  AST_RD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cause_rd |=> !irq);                                                  // R11
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq);                                                   // R12
  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wb_req |-> $past(done[0] || tick));                               // R6
endmodule

// File: tb/sim_nic_irq_moderator.sv
module sim_nic_irq_moderator;
  localparam int P  = 4;
  localparam int TW = 8;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_done = 0, tx_done = 0, cfg_we = 0, mask_we = 0;
  logic post_valid = 0, post_now = 0, cause_rd = 0, irq_clr = 0;
  logic [2:0]    cfg_sel = '0;
  logic [TW-1:0] cfg_wdata = '0;
  logic [NC-1:0] mask_wdata = '0, post_cause = '0;
  logic [NC-1:0] cause_q;
  logic rx_wb_req, tx_wb_req, irq;

  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  nic_irq_moderator #(.PRESCALE(P), .TW(TW), .NC(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .tx_done(tx_done),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .post_valid(post_valid),
    .post_cause(post_cause), .post_now(post_now), .cause_rd(cause_rd),
    .irq_clr(irq_clr), .cause_q(cause_q), .rx_wb_req(rx_wb_req),
    .tx_wb_req(tx_wb_req), .irq(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, compared every cycle
  int pc, thr, thrcfg;
  int pk[2], ab[2], pkcfg[2], abcfg[2];
  bit wbm[2];
  bit irqm;
  logic [NC-1:0] pendm, maskm;

  always @(posedge clk) begin
    bit tick, live, imm, irqn;
    bit dn[2];
    bit fr[2];
    logic [NC-1:0] setb, mn, pn;
    if (!rst_n) begin
      pc = 0; thr = 0; thrcfg = 0; irqm = 0; pendm = '0; maskm = '0;
      for (int p = 0; p < 2; p++) begin pk[p] = 0; ab[p] = 0; pkcfg[p] = 0; abcfg[p] = 0; wbm[p] = 0; end
    end else begin
      tick = (pc == P - 1);
      pc = tick ? 0 : pc + 1;
      dn[0] = rx_done; dn[1] = tx_done;
      for (int p = 0; p < 2; p++) begin
        fr[p] = (tick && (pk[p] == 1 || ab[p] == 1)) || (dn[p] && pkcfg[p] == 0);
        if (fr[p]) begin pk[p] = 0; ab[p] = 0; end
        else begin
          if (tick && pk[p] > 0) pk[p]--;
          if (tick && ab[p] > 0) ab[p]--;
          if (dn[p]) begin
            pk[p] = pkcfg[p];
            if (ab[p] == 0) ab[p] = abcfg[p];
          end
        end
        wbm[p] = fr[p];
      end
      setb = '0; setb[1] = fr[0]; setb[0] = fr[1];
      if (post_valid) setb = setb | post_cause;
      pn = (cause_rd ? '0 : pendm) | setb;
      mn = mask_we ? mask_wdata : maskm;
      live = |(pn & mn);
      imm = post_valid && post_now && |(post_cause & mn);
      irqn = !(cause_rd || irq_clr) && live && (irqm || thr == 0 || imm);
      if (irqn && !irqm) thr = thrcfg;
      else if (tick && thr > 0) thr--;
      irqm = irqn; pendm = pn; maskm = mn;
      if (cfg_we) begin
        if (cfg_sel == 0) pkcfg[0] = cfg_wdata;
        if (cfg_sel == 1) abcfg[0] = cfg_wdata;
        if (cfg_sel == 2) pkcfg[1] = cfg_wdata;
        if (cfg_sel == 3) abcfg[1] = cfg_wdata;
        if (cfg_sel == 4) thrcfg = cfg_wdata;
      end
    end
    #1;
    chk(irq === irqm, "R7 model irq", irq, irqm);
    chk(cause_q === pendm, "R11 model cause_q", cause_q, pendm);
    chk(rx_wb_req === wbm[0], "R2 model rx_wb_req", rx_wb_req, wbm[0]);
    chk(tx_wb_req === wbm[1], "R3 model tx_wb_req", tx_wb_req, wbm[1]);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int sel, input int val);
    @(negedge clk); cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = TW'(val);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic setmask(input int m);
    @(negedge clk); mask_we = 1; mask_wdata = NC'(m);
    @(negedge clk); mask_we = 0;
  endtask

  task automatic rxp();
    @(negedge clk); rx_done = 1; @(negedge clk); rx_done = 0;
  endtask

  task automatic txp();
    @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
  endtask

  task automatic rd();
    @(negedge clk); cause_rd = 1; @(negedge clk); cause_rd = 0;
  endtask

  task automatic clr();
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask

  task automatic post(input int c, input bit now);
    @(negedge clk); post_valid = 1; post_cause = NC'(c); post_now = now;
    @(negedge clk); post_valid = 0; post_now = 0; post_cause = '0;
  endtask

  task automatic wait_tx(output int n);
    n = 1;
    while (!tx_wb_req && n < 64) begin @(negedge clk); n++; end
  endtask

  task automatic wait_rx(output int n);
    n = 1;
    while (!rx_wb_req && n < 64) begin @(negedge clk); n++; end
  endtask

  task automatic wait_irq(output int n);
    n = 1;
    while (!irq && n < 64) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(4 * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int n, first;
    cyc(3);
    @(negedge clk); rst_n = 1;
    chk(irq == 0 && cause_q == 0, "R7 reset state", int'(irq), 0);
    chk(rx_wb_req == 0 && tx_wb_req == 0, "R2 reset wb idle", int'(rx_wb_req), 0);

    setmask(4'hF);
    rxp();
    chk(rx_wb_req == 1, "R6 zero delay writes back next cycle", int'(rx_wb_req), 1);
    chk(cause_q[1] == 1, "R2 receive cause set", int'(cause_q[1]), 1);
    chk(irq == 1, "R7 unmasked cause raises irq", int'(irq), 1);
    rd();
    chk(irq == 0 && cause_q == 0, "R11 read clears and drops", int'(cause_q), 0);

    cfg(7, 9);
    txp();
    chk(tx_wb_req == 1 && cause_q[0] == 1, "R7 unused selector ignored", int'(tx_wb_req), 1);
    rd();

    cfg(2, 1);
    txp();
    wait_tx(n);
    chk(n >= 1 && n <= 5, "R1 one-tick delay latency", n, 3);

    cfg(2, 3);
    txp();
    wait_tx(n);
    chk(n >= 9 && n <= 13, "R3 three-tick delay latency", n, 11);
    chk(cause_q[0] == 1, "R3 transmit cause set", int'(cause_q[0]), 1);
    rd();

    txp(); cyc(5); txp();
    wait_tx(n);
    chk(n >= 9, "R4 packet timer restarted", n, 11);
    rd();

    cfg(2, 5); cfg(3, 4);
    first = 0;
    for (int i = 0; i < 30 && first == 0; i++) begin
      @(negedge clk); tx_done = (i % 3 == 0);
      if (tx_wb_req) first = i;
    end
    @(negedge clk); tx_done = 0;
    chk(first >= 12 && first <= 19, "R5 absolute timer not pushed back", first, 15);
    rd();

    cfg(0, 2);
    rxp();
    wait_rx(n);
    chk(n >= 5 && n <= 9, "R2 receive timer writeback", n, 7);
    rd();
    cfg(0, 0);

    cyc(40);
    cfg(4, 5);
    rxp();
    chk(irq == 1, "R8 first rise allowed", int'(irq), 1);
    rd();
    rxp();
    chk(irq == 0, "R8 held by throttle", int'(irq), 0);
    wait_irq(n);
    chk(n >= 12 && n <= 21, "R8 held cause raised at end of interval", n, 16);
    rd();
    post(4'h4, 1'b0);
    chk(irq == 0, "R8 normal post held", int'(irq), 0);
    post(4'h8, 1'b1);
    chk(irq == 1, "R9 immediate post bypasses throttle", int'(irq), 1);

    setmask(0);
    chk(irq == 0 && cause_q != 0, "R10 masking drops line", int'(irq), 0);
    cyc(30);
    setmask(4'hF);
    chk(irq == 1, "R10 unmasking raises line", int'(irq), 1);

    clr();
    chk(irq == 0, "R12 clear drops line", int'(irq), 0);
    wait_irq(n);
    chk(n >= 12 && n <= 21, "R12 pending cause re-raised after throttle", n, 16);
    rd();
    cyc(4);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule